// File: doc/BRIEF.md
# Prefetch Duplicate Suppression Filter

This block sits between the logic that proposes prefetch addresses and the port that sends requests to memory. Each proposed address is reduced to its 64-byte cache-block number. Two XOR-fold hashes of that number each pick one bit in a bit vector. If both picked bits are already set, the block was very likely requested a short time ago. The candidate is then dropped. Otherwise the candidate is passed on and both of its bits are set in the same cycle.

The vector has no way to delete single entries. Bits from many blocks overlap, so a block that was never sent can still look present. Such a false positive drops a useful prefetch, and that loss is accepted. To keep false positives rare, the filter counts its accesses and wipes the whole vector once every quarter of its bit count. With the default 2048-bit vector this is every 512 accesses. A 4096-bit vector is selected through a parameter.

Each candidate that arrives on `cand_valid_i` gets its verdict one clock later. The verdict is either a forwarded request on `issue_valid_o`/`issue_addr_o` or a pulse on `drop_o`.

Top module: `pf_dedup_bloom`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `issue_valid_o` and `drop_o` are 0. After reset the vector is empty and the access count is zero, so the first candidate is issued.
- R2: The low log2(BLK_BYTES) address bits (6 by default) are ignored. Two addresses with the same block number give the same verdict.
- R3: The block number is blk = addr >> 6, with BLK_W = ADDR_W-6 bits. The index width is IDX_W = log2(FILT_BITS). Hash A is the XOR of all blk bits i whose position i mod IDX_W equals the index bit. Hash B is built the same way, but bit i is placed at position (BLK_W-1-i) mod IDX_W.
- R4: A candidate whose hash A bit and hash B bit are both set is dropped. `drop_o` is 1 and `issue_valid_o` is 0 in the next cycle.
- R5: Any other candidate is issued. In the next cycle `issue_valid_o` is 1 and `issue_addr_o` equals the full candidate address. Both of its bits are set from then on.
- R6: Every valid candidate produces exactly one of issue or drop in the next cycle. A cycle without a candidate produces neither.
- R7: Let P = FILT_BITS/4. Accesses 1 to P after a reset or after a wipe use the current vector. Access P+1 first clears the whole vector, then probes and inserts. That access is therefore issued, and it counts as access 1 of the new window.
- R8: A block that was never sent is dropped when other blocks have already set both of its bits. This is an accepted false positive.
- R9: A block repeated within one window is dropped each time after its first issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cand_valid_i | input | 1 | Candidate prefetch present this cycle |
| cand_addr_i | input | ADDR_W | Candidate byte address |
| issue_valid_o | output | 1 | Forwarded prefetch request, one cycle after the candidate |
| issue_addr_o | output | ADDR_W | Address of the forwarded request |
| drop_o | output | 1 | Candidate was judged a duplicate and discarded |

## Verification
Two functions can fall in the same cycle: the periodic whole-vector wipe and the probe and insert of a candidate. The bench provokes this with a directed sequence. It sends a block, fills the window with another block up to access P, repeats the first block at access P (expected drop), then sends it again at access P+1. That last access must be issued and must leave only its own bits set, so an immediate repeat is dropped. A long mixed random stream crosses several window boundaries, with a behavioural model compared on every clock.

// File: rtl/pf_dedup_pkg.sv
package pf_dedup_pkg;

    localparam int DEF_ADDR_W    = 32;
    localparam int DEF_BLK_BYTES = 64;
    localparam int DEF_FILT_BITS = 2048;
    localparam int NUM_HASH      = 2;

    typedef enum logic [1:0] {
        VERD_NONE  = 2'd0,
        VERD_ISSUE = 2'd1,
        VERD_DROP  = 2'd2
    } verdict_e;

    function automatic verdict_e judge(input logic valid, input logic seen);
        if (!valid)
            return VERD_NONE;
        return seen ? VERD_DROP : VERD_ISSUE;
    endfunction

endpackage

// File: rtl/pf_dedup_hash.sv
module pf_dedup_hash #(
    parameter int BLK_W  = 26,
    parameter int IDX_W  = 11,
    parameter bit MIRROR = 1'b0
) (
    input  logic [BLK_W-1:0] blk_i,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < BLK_W; i++) begin
            if (MIRROR)
                idx_o[(BLK_W - 1 - i) % IDX_W] = idx_o[(BLK_W - 1 - i) % IDX_W] ^ blk_i[i];
            else
                idx_o[i % IDX_W] = idx_o[i % IDX_W] ^ blk_i[i];
        end
    end
endmodule

// File: rtl/pf_dedup_window.sv
module pf_dedup_window #(
    parameter int PERIOD = 512
) (
    input  logic clk,
    input  logic rst,
    input  logic access_i,
    output logic wipe_o
);
    localparam int CNT_W = $clog2(PERIOD + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(PERIOD);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    assign wipe_o = access_i && (cnt_q == FULL);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (access_i)
            cnt_q <= wipe_o ? ONE : cnt_q + ONE;
    end
endmodule

// File: rtl/pf_dedup_bits.sv
module pf_dedup_bits #(
    parameter int NBITS = 2048,
    parameter int IDX_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wipe_i,
    input  logic             set_i,
    input  logic [IDX_W-1:0] idx_a_i,
    input  logic [IDX_W-1:0] idx_b_i,
    output logic             seen_o
);
    logic [NBITS-1:0] vec_q;
    logic [NBITS-1:0] vec_n;

    assign seen_o = !wipe_i && vec_q[idx_a_i] && vec_q[idx_b_i];

    always_comb begin
        vec_n = wipe_i ? '0 : vec_q;
        if (set_i) begin
            vec_n[idx_a_i] = 1'b1;
            vec_n[idx_b_i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            vec_q <= '0;
        else
            vec_q <= vec_n;
    end
endmodule

// File: rtl/pf_dedup_bloom.sv
module pf_dedup_bloom
    import pf_dedup_pkg::*;
#(
    parameter int ADDR_W    = DEF_ADDR_W,
    parameter int BLK_BYTES = DEF_BLK_BYTES,
    parameter int FILT_BITS = DEF_FILT_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cand_valid_i,
    input  logic [ADDR_W-1:0] cand_addr_i,
    output logic              issue_valid_o,
    output logic [ADDR_W-1:0] issue_addr_o,
    output logic              drop_o
);
    localparam int OFF_W  = $clog2(BLK_BYTES);
    localparam int BLK_W  = ADDR_W - OFF_W;
    localparam int IDX_W  = $clog2(FILT_BITS);
    localparam int PERIOD = FILT_BITS / 4;

    logic [BLK_W-1:0] blk_w;
    logic [IDX_W-1:0] idx_w [NUM_HASH];
    logic             wipe_w;
    logic             seen_w;
    logic             set_w;
    verdict_e         verd_q;

    assign blk_w = cand_addr_i[ADDR_W-1:OFF_W];

    for (genvar g = 0; g < NUM_HASH; g++) begin : g_hash
        pf_dedup_hash #(
            .BLK_W (BLK_W),
            .IDX_W (IDX_W),
            .MIRROR(g[0])
        ) hash_i (
            .blk_i(blk_w),
            .idx_o(idx_w[g])
        );
    end

    pf_dedup_window #(
        .PERIOD(PERIOD)
    ) window_i (
        .clk     (clk),
        .rst     (rst),
        .access_i(cand_valid_i),
        .wipe_o  (wipe_w)
    );

    assign set_w = cand_valid_i && !seen_w;

    pf_dedup_bits #(
        .NBITS(FILT_BITS),
        .IDX_W(IDX_W)
    ) bits_i (
        .clk    (clk),
        .rst    (rst),
        .wipe_i (wipe_w),
        .set_i  (set_w),
        .idx_a_i(idx_w[0]),
        .idx_b_i(idx_w[1]),
        .seen_o (seen_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            verd_q       <= VERD_NONE;
            issue_addr_o <= '0;
        end else begin
            verd_q <= judge(cand_valid_i, seen_w);
            if (cand_valid_i)
                issue_addr_o <= cand_addr_i;
        end
    end

    assign issue_valid_o = (verd_q == VERD_ISSUE);
    assign drop_o        = (verd_q == VERD_DROP);
endmodule

// File: rtl/pf_dedup_bloom_chk.sv
module pf_dedup_bloom_chk #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              cand_valid_i,
    input logic [ADDR_W-1:0] cand_addr_i,
    input logic              issue_valid_o,
    input logic [ADDR_W-1:0] issue_addr_o,
    input logic              drop_o,
    input logic              wipe
);
    // R6
    verdict_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({issue_valid_o, drop_o}));

    // R6
    verdict_given_chk: assert property (@(posedge clk) disable iff (rst)
        cand_valid_i |=> (issue_valid_o || drop_o));

    // R6
    verdict_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !cand_valid_i |=> (!issue_valid_o && !drop_o));

    // R5
    issue_addr_chk: assert property (@(posedge clk) disable iff (rst)
        cand_valid_i |=> (issue_addr_o == $past(cand_addr_i)));

    // R7
    wipe_issue_chk: assert property (@(posedge clk) disable iff (rst)
        wipe |=> issue_valid_o);

    // R7
    wipe_needs_access_chk: assert property (@(posedge clk) disable iff (rst)
        wipe |-> cand_valid_i);

    // R9
    repeat_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (cand_valid_i && $past(cand_valid_i) && !$past(rst) && !wipe &&
         (cand_addr_i[ADDR_W-1:OFF_W] == $past(cand_addr_i[ADDR_W-1:OFF_W])))
        |=> drop_o);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!issue_valid_o && !drop_o));
endmodule

bind pf_dedup_bloom pf_dedup_bloom_chk #(
    .ADDR_W(ADDR_W),
    .OFF_W (OFF_W)
) chk_i (
    .clk          (clk),
    .rst          (rst),
    .cand_valid_i (cand_valid_i),
    .cand_addr_i  (cand_addr_i),
    .issue_valid_o(issue_valid_o),
    .issue_addr_o (issue_addr_o),
    .drop_o       (drop_o),
    .wipe         (wipe_w)
);

// File: tb/pf_dedup_bloom_tb.sv
module pf_dedup_bloom_tb_top;
    localparam int ADDR_W = 32;
    localparam int FILT   = 2048;
    localparam int OFFW   = 6;
    localparam int BLKW   = ADDR_W - OFFW;
    localparam int IDXW   = 11;
    localparam int PER    = FILT / 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cand_valid_i = 1'b0;
    logic [ADDR_W-1:0] cand_addr_i = '0;
    logic              issue_valid_o;
    logic [ADDR_W-1:0] issue_addr_o;
    logic              drop_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    pf_dedup_bloom #(.ADDR_W(ADDR_W), .BLK_BYTES(64), .FILT_BITS(FILT)) dut_i (
        .clk(clk), .rst(rst), .cand_valid_i(cand_valid_i), .cand_addr_i(cand_addr_i),
        .issue_valid_o(issue_valid_o), .issue_addr_o(issue_addr_o), .drop_o(drop_o));

    // R3 hashes written from the requirement text
    function automatic int hsh(logic [ADDR_W-1:0] a, bit mir);
        logic [BLKW-1:0] b;
        int r;
        b = a[ADDR_W-1:OFFW];
        r = 0;
        for (int i = 0; i < BLKW; i++) begin
            if (b[i]) r = r ^ (1 << ((mir ? (BLKW - 1 - i) : i) % IDXW));
        end
        return r;
    endfunction

    // reference model
    bit              mbits [FILT];
    int              mcnt = 0;
    bit              e_iss = 0, e_drp = 0;
    logic [ADDR_W-1:0] e_addr = '0;
    bit              mod_live = 0;

    always @(posedge clk) begin
        if (rst) begin
            foreach (mbits[k]) mbits[k] = 0;
            mcnt = 0; e_iss = 0; e_drp = 0; e_addr = '0;
        end else if (cand_valid_i) begin
            int ha, hb;
            bit hit;
            if (mcnt == PER) begin
                foreach (mbits[k]) mbits[k] = 0;
                mcnt = 0;
            end
            ha = hsh(cand_addr_i, 1'b0);
            hb = hsh(cand_addr_i, 1'b1);
            hit = mbits[ha] && mbits[hb];
            if (!hit) begin mbits[ha] = 1; mbits[hb] = 1; end
            mcnt++;
            e_iss = !hit; e_drp = hit; e_addr = cand_addr_i;
        end else begin
            e_iss = 0; e_drp = 0;
        end
        mod_live = 1;
    end

    // per-clock comparison, away from the active edge (R4 R5 R6)
    always @(negedge clk) begin
        if (mod_live) begin
            n_cmp++;
            if (issue_valid_o !== e_iss || drop_o !== e_drp ||
                (e_iss && issue_addr_o !== e_addr)) begin
                n_bad++;
                $display("FAIL R4/R5/R6 model: issue=%0b drop=%0b addr=%h expected issue=%0b drop=%0b addr=%h",
                         issue_valid_o, drop_o, issue_addr_o, e_iss, e_drp, e_addr);
            end
        end
    end

    task automatic drive(bit v, logic [ADDR_W-1:0] a);
        @(negedge clk);
        #1;
        cand_valid_i = v;
        cand_addr_i  = a;
    endtask

    task automatic chk(string req, bit act_iss, bit act_drp, bit exp_iss, bit exp_drp);
        n_cmp++;
        if (act_iss !== exp_iss || act_drp !== exp_drp) begin
            n_bad++;
            $display("FAIL %s: issue=%0b drop=%0b expected issue=%0b drop=%0b",
                     req, act_iss, act_drp, exp_iss, exp_drp);
        end
    endtask

    // send one candidate then idle; result is visible when this returns
    task automatic probe(logic [ADDR_W-1:0] a, string req, bit exp_iss);
        drive(1'b1, a);
        drive(1'b0, '0);
        chk(req, issue_valid_o, drop_o, exp_iss, !exp_iss);
    endtask

    task automatic do_reset();
        drive(1'b0, '0);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 outputs in reset", issue_valid_o, drop_o, 1'b0, 1'b0);
        rst = 1'b0;
    endtask

    initial begin
        logic [ADDR_W-1:0] a_blk, b_blk, c_blk, fa, fb;
        bit found_a, found_b;

        repeat (3) @(negedge clk);
        #1;
        chk("R1 outputs in reset", issue_valid_o, drop_o, 1'b0, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk("R1 first cycle after reset", issue_valid_o, drop_o, 1'b0, 1'b0);

        a_blk = 32'h0001_2340;
        b_blk = 32'h00AB_CD80;
        probe(a_blk, "R1 first candidate issued", 1'b1);
        probe(a_blk, "R9 repeat dropped", 1'b0);
        probe(a_blk | 32'h3F, "R2 low bits ignored", 1'b0);
        probe(a_blk + 32'h40, "R5 next block issued", 1'b1);

        // R7: window boundary coincides with a candidate
        do_reset();
        drive(1'b1, a_blk);                               // access 1
        for (int i = 2; i < PER; i++) drive(1'b1, b_blk); // accesses 2..P-1
        drive(1'b1, a_blk | 32'h11);                      // access P
        drive(1'b0, '0);
        chk("R9 repeat at last access of window", issue_valid_o, drop_o, 1'b0, 1'b1);
        probe(a_blk, "R7 wipe then insert issues", 1'b1);
        probe(a_blk, "R7 inserted after wipe, repeat dropped", 1'b0);
        probe(b_blk, "R7 old contents forgotten", 1'b1);

        // R1: mid-run reset empties the filter
        do_reset();
        probe(b_blk, "R1 reset clears filter", 1'b1);

        // R8: false positive built from two other blocks
        c_blk = 32'h0765_4300;
        found_a = 0; found_b = 0; fa = '0; fb = '0;
        for (int k = 1; k < (1 << 20) && !(found_a && found_b); k++) begin
            logic [ADDR_W-1:0] t;
            t = ADDR_W'(k) << OFFW;
            if (t[ADDR_W-1:OFFW] != c_blk[ADDR_W-1:OFFW]) begin
                if (!found_a && hsh(t, 1'b0) == hsh(c_blk, 1'b0)) begin fa = t; found_a = 1; end
                else if (!found_b && hsh(t, 1'b1) == hsh(c_blk, 1'b1)) begin fb = t; found_b = 1; end
            end
        end
        do_reset();
        if (found_a && found_b) begin
            probe(fa, "R8 first helper issued", 1'b1);
            drive(1'b1, fb);
            drive(1'b0, '0);
            probe(c_blk, "R8 unseen block dropped", 1'b0);
        end else begin
            n_cmp++; n_bad++;
            $display("FAIL R8 helper search: found=%0b%0b expected 11", found_a, found_b);
        end

        // mixed random stream across several windows (R4 R5 R6 R7 R9)
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            logic [ADDR_W-1:0] ad;
            if ($urandom_range(0, 9) < 7)
                ad = (ADDR_W'($urandom_range(0, 39)) << OFFW) | ADDR_W'($urandom_range(0, 63));
            else
                ad = ADDR_W'($urandom());
            drive($urandom_range(0, 9) < 7, ad);
        end
        drive(1'b0, '0);
        repeat (2) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: cycles=200000 expected completion earlier");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule